// File: doc/BRIEF.md
# Power-Management Command Port Controller

This block sits behind a single byte-wide command port that firmware or an operating system writes to ask for power-management actions. Each accepted write is classified. Two reserved command codes are handled inside the block: one turns the system-control-interrupt enable level on and the other turns it off. Every other code is a request for a system-management interrupt. That request becomes a one-cycle pulse only when a gating bit is set in a small bank of configuration bytes that the block holds.

The configuration bank is reached through a word-wide, byte-enabled register port with a synchronous write strobe and a combinational read. Reset clears the whole bank. A strap input can instead mark system-management mode as already initialised at reset, and in that case the gate byte is loaded with a fixed value. The SCI enable is driven as a level so that an interrupt-routing block elsewhere can combine it with its own status and enable bits. The last command code written can always be read back.

Top module: `apm_cmd_ctrl`

## Requirements
- R1: A command write of 0xF1 drives `sci_en` high from the clock edge that accepts the write.
- R2: A command write of 0xF0 drives `sci_en` low from the clock edge that accepts the write.
- R3: Command writes of 0xF0 and 0xF1 never assert `smi_pulse`, whatever value the gate bit holds.
- R4: A command write of any other code asserts `smi_pulse` for exactly the one cycle that follows the accepting edge, but only when the gate bit is 1. The gate bit is bit 1 of configuration lane 3, which is `cfg_rdata[25]`. When the gate bit is 0, no pulse is issued.
- R5: Idle cycles and writes of codes other than 0xF0 and 0xF1 leave `sci_en` unchanged.
- R6: `last_cmd` holds the code of the most recent command write, updated at the accepting edge, and reads 0 after reset.
- R7: When `cfg_wr` is high, each lane i whose `cfg_be[i]` is set takes `cfg_wdata[8i+7:8i]` at the edge. Lanes whose enable is clear keep their value. `cfg_rdata[8i+7:8i]` always shows lane i.
- R8: Reset (synchronous, active high) clears all configuration lanes and sets `sci_en`, `smi_pulse` and `last_cmd` to 0. If `smm_off_strap` is high during reset, lane 3 is loaded with 0x02 instead, which sets the gate bit.
- R9: When a command write and a configuration write occur in the same cycle, the gate value held before that edge decides whether `smi_pulse` is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smm_off_strap | input | 1 | Marks system-management mode as already set up at reset |
| cmd_wr | input | 1 | Command port write strobe |
| cmd_data | input | 8 | Command code |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Per-lane byte enables |
| cfg_wdata | input | 32 | Configuration write data, lane i in bits 8i+7:8i |
| cfg_rdata | output | 32 | Configuration read data, same lane layout |
| last_cmd | output | 8 | Last command code written |
| sci_en | output | 1 | SCI enable level |
| smi_pulse | output | 1 | One-cycle system-management interrupt request |

## Verification
The bench builds the block with its default parameters: four configuration lanes, the gate in lane 3 bit 1, 0xF1 and 0xF0 as the reserved codes, and 0x02 as the strap value. With these values the random byte enables and write data can reach every lane, including the lane that holds the gate. The command stream is biased toward the two reserved codes, so that SCI toggling, gate changes and simultaneous configuration writes interleave often. Directed cases cover both strap settings at reset, reserved codes with the gate set, and a gate change written in the same cycle as a command.

// File: rtl/apm_pkg.sv
package apm_pkg;

    localparam int unsigned CMD_W        = 8;
    localparam int unsigned CFG_LANES    = 4;
    localparam int unsigned LANE_W       = 8;
    localparam logic [7:0]  CODE_SCI_ON  = 8'hF1;
    localparam logic [7:0]  CODE_SCI_OFF = 8'hF0;
    localparam int unsigned GATE_LANE    = 3;
    localparam int unsigned GATE_BIT     = 1;
    localparam logic [7:0]  STRAP_VALUE  = 8'h02;

    typedef enum logic [1:0] {
        CMD_IDLE    = 2'd0,
        CMD_SCI_SET = 2'd1,
        CMD_SCI_CLR = 2'd2,
        CMD_SMI_REQ = 2'd3
    } apm_kind_e;

    typedef struct packed {
        apm_kind_e        kind;
        logic [CMD_W-1:0] code;
    } apm_cmd_t;

    function automatic apm_kind_e classify(input logic wr,
                                           input logic [CMD_W-1:0] code,
                                           input logic [CMD_W-1:0] on_code,
                                           input logic [CMD_W-1:0] off_code);
        if (!wr)                  return CMD_IDLE;
        else if (code == on_code) return CMD_SCI_SET;
        else if (code == off_code) return CMD_SCI_CLR;
        else                      return CMD_SMI_REQ;
    endfunction

endpackage

// File: rtl/apm_cmd_decode.sv
module apm_cmd_decode
    import apm_pkg::*;
#(
    parameter int unsigned    W       = CMD_W,
    parameter logic [W-1:0]   ON_CODE = CODE_SCI_ON,
    parameter logic [W-1:0]   OFF_CODE = CODE_SCI_OFF
) (
    input  logic         wr,
    input  logic [W-1:0] data,
    output apm_cmd_t     cmd
);
    always_comb begin
        cmd.kind = classify(wr, data, ON_CODE, OFF_CODE);
        cmd.code = data;
    end
endmodule

// File: rtl/apm_cfg_bank.sv
module apm_cfg_bank
    import apm_pkg::*;
#(
    parameter int unsigned     LANES     = CFG_LANES,
    parameter int unsigned     LW        = LANE_W,
    parameter int unsigned     G_LANE    = GATE_LANE,
    parameter int unsigned     G_BIT     = GATE_BIT,
    parameter logic [LW-1:0]   STRAP_VAL = STRAP_VALUE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                strap,
    input  logic                wr,
    input  logic [LANES-1:0]    be,
    input  logic [LANES*LW-1:0] wdata,
    output logic [LANES*LW-1:0] rdata,
    output logic                gate
);
    logic [LW-1:0] lane_q [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam bit IS_GATE = (i == G_LANE);

        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q[i] <= (IS_GATE && strap) ? STRAP_VAL : '0;
            end else if (wr && be[i]) begin
                lane_q[i] <= wdata[i*LW +: LW];
            end
        end

        assign rdata[i*LW +: LW] = lane_q[i];

        AST_CFG_LANE_WRITE: assert property (@(posedge clk) disable iff (rst)
            (wr && be[i]) |=> rdata[i*LW +: LW] == $past(wdata[i*LW +: LW])); // R7
        AST_CFG_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
            !(wr && be[i]) |=> $stable(rdata[i*LW +: LW])); // R7
    end

    assign gate = lane_q[G_LANE][G_BIT];
endmodule

// File: rtl/apm_pm_out.sv
module apm_pm_out
    import apm_pkg::*;
#(
    parameter int unsigned W = CMD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  apm_cmd_t     cmd,
    input  logic         gate,
    output logic         sci_en,
    output logic         smi_pulse,
    output logic [W-1:0] last_cmd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sci_en    <= 1'b0;
            smi_pulse <= 1'b0;
            last_cmd  <= '0;
        end else begin
            smi_pulse <= (cmd.kind == CMD_SMI_REQ) && gate;
            if (cmd.kind != CMD_IDLE) begin
                last_cmd <= cmd.code[W-1:0];
            end
            unique case (cmd.kind)
                CMD_SCI_SET: sci_en <= 1'b1;
                CMD_SCI_CLR: sci_en <= 1'b0;
                default:     sci_en <= sci_en;
            endcase
        end
    end

    AST_SMI_NEEDS_GATE: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind == CMD_SMI_REQ && !gate) |=> !smi_pulse); // R4
    AST_SMI_WHEN_GATED: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind == CMD_SMI_REQ && gate) |=> smi_pulse); // R4
endmodule

// File: rtl/apm_cmd_ctrl.sv
module apm_cmd_ctrl
    import apm_pkg::*;
#(
    parameter int unsigned       LANES    = CFG_LANES,
    parameter logic [CMD_W-1:0]  ON_CODE  = CODE_SCI_ON,
    parameter logic [CMD_W-1:0]  OFF_CODE = CODE_SCI_OFF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smm_off_strap,
    input  logic                    cmd_wr,
    input  logic [CMD_W-1:0]        cmd_data,
    input  logic                    cfg_wr,
    input  logic [LANES-1:0]        cfg_be,
    input  logic [LANES*LANE_W-1:0] cfg_wdata,
    output logic [LANES*LANE_W-1:0] cfg_rdata,
    output logic [CMD_W-1:0]        last_cmd,
    output logic                    sci_en,
    output logic                    smi_pulse
);
    apm_cmd_t cmd;
    logic     gate;

    apm_cmd_decode #(.W(CMD_W), .ON_CODE(ON_CODE), .OFF_CODE(OFF_CODE)) u_dec (
        .wr   (cmd_wr),
        .data (cmd_data),
        .cmd  (cmd)
    );

    apm_cfg_bank #(.LANES(LANES), .LW(LANE_W), .G_LANE(GATE_LANE),
                   .G_BIT(GATE_BIT), .STRAP_VAL(STRAP_VALUE)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .strap (smm_off_strap),
        .wr    (cfg_wr),
        .be    (cfg_be),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .gate  (gate)
    );

    apm_pm_out #(.W(CMD_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .gate      (gate),
        .sci_en    (sci_en),
        .smi_pulse (smi_pulse),
        .last_cmd  (last_cmd)
    );

    AST_SCI_SET: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_data == ON_CODE) |=> sci_en); // R1
    AST_SCI_CLR: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_data == OFF_CODE) |=> !sci_en); // R2
    AST_RESERVED_NO_SMI: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && (cmd_data == ON_CODE || cmd_data == OFF_CODE)) |=> !smi_pulse); // R3
    AST_SMI_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        !cmd_wr |=> !smi_pulse); // R4
    AST_SCI_STABLE: assert property (@(posedge clk) disable iff (rst)
        !(cmd_wr && (cmd_data == ON_CODE || cmd_data == OFF_CODE)) |=> $stable(sci_en)); // R5
    AST_LAST_CMD: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> last_cmd == $past(cmd_data)); // R6
endmodule

// File: tb/apm_cmd_ctrl_tb.sv
module apm_cmd_ctrl_tb;
    localparam int LN = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            smm_off_strap = 1'b0;
    logic            cmd_wr = 1'b0;
    logic [7:0]      cmd_data = '0;
    logic            cfg_wr = 1'b0;
    logic [LN-1:0]   cfg_be = '0;
    logic [LN*8-1:0] cfg_wdata = '0;
    logic [LN*8-1:0] cfg_rdata;
    logic [7:0]      last_cmd;
    logic            sci_en;
    logic            smi_pulse;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [7:0] m_lane [LN];
    logic       m_sci;
    logic       m_smi;
    logic [7:0] m_last;

    apm_cmd_ctrl u_dut (
        .clk(clk), .rst(rst), .smm_off_strap(smm_off_strap),
        .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .last_cmd(last_cmd),
        .sci_en(sci_en), .smi_pulse(smi_pulse)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] pack_lanes();
        logic [31:0] v;
        for (int i = 0; i < LN; i++) v[i*8 +: 8] = m_lane[i];
        return v;
    endfunction

    function automatic logic is_reserved(input logic [7:0] c);
        return (c == 8'hF1) || (c == 8'hF0);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R1/R2/R5 sci_en"}, {31'd0, sci_en}, {31'd0, m_sci});
        chk({tag, " R3/R4/R9 smi_pulse"}, {31'd0, smi_pulse}, {31'd0, m_smi});
        chk({tag, " R6 last_cmd"}, {24'd0, last_cmd}, {24'd0, m_last});
        chk({tag, " R7 cfg_rdata"}, cfg_rdata, pack_lanes());
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst = 1'b1; smm_off_strap = strap;
        cmd_wr = 1'b0; cfg_wr = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < LN; i++) m_lane[i] = 8'h00;
        if (strap) m_lane[3] = 8'h02;
        m_sci = 1'b0; m_smi = 1'b0; m_last = 8'h00;
        check_all("R8 reset");
    endtask

    // Applies one cycle of stimulus; the model is advanced from the requirements.
    task automatic cyc(input logic cw, input logic [7:0] cd, input logic fw,
                       input logic [3:0] be, input logic [31:0] wd, input string tag);
        logic gate_old;
        cmd_wr = cw; cmd_data = cd; cfg_wr = fw; cfg_be = be; cfg_wdata = wd;
        gate_old = m_lane[3][1];
        m_smi = cw && !is_reserved(cd) && gate_old;
        if (cw) begin
            m_last = cd;
            if (cd == 8'hF1) m_sci = 1'b1;
            else if (cd == 8'hF0) m_sci = 1'b0;
        end
        if (fw) for (int i = 0; i < LN; i++) if (be[i]) m_lane[i] = wd[i*8 +: 8];
        @(posedge clk); #2;
        cmd_wr = 1'b0; cfg_wr = 1'b0;
        check_all(tag);
        @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset(1'b0);                                            // R8 strap low
        cyc(1'b1, 8'h55, 1'b0, 4'h0, 32'h0, "R4 gate=0 no smi");
        cyc(1'b1, 8'hF1, 1'b0, 4'h0, 32'h0, "R1 set");
        cyc(1'b0, 8'h00, 1'b0, 4'h0, 32'h0, "R5 idle");
        cyc(1'b1, 8'h33, 1'b0, 4'h0, 32'h0, "R5 other code");
        cyc(1'b1, 8'hF0, 1'b0, 4'h0, 32'h0, "R2 clear");
        cyc(1'b0, 8'h00, 1'b1, 4'h5, 32'hAABBCCDD, "R7 partial be");
        // R9: gate written to 1 in the same cycle as a command: old gate (0) decides
        cyc(1'b1, 8'h12, 1'b1, 4'h8, 32'h02000000, "R9 same-cycle");
        cyc(1'b1, 8'h13, 1'b0, 4'h0, 32'h0, "R4 gated pulse");
        cyc(1'b0, 8'h00, 1'b0, 4'h0, 32'h0, "R4 pulse one cycle");
        cyc(1'b1, 8'hF1, 1'b0, 4'h0, 32'h0, "R3 F1 gate=1");
        cyc(1'b1, 8'hF0, 1'b0, 4'h0, 32'h0, "R3 F0 gate=1");
        do_reset(1'b1);                                            // R8 strap high
        cyc(1'b1, 8'h77, 1'b0, 4'h0, 32'h0, "R8 strap gate smi");
        for (int n = 0; n < 600; n++) begin
            logic [7:0] c;
            int sel;
            sel = $urandom_range(0, 3);
            c = (sel == 0) ? 8'hF1 : (sel == 1) ? 8'hF0 : 8'($urandom);
            cyc(1'($urandom_range(0, 1)), c, ($urandom_range(0, 4) == 0),
                4'($urandom), $urandom, "random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule